// File: doc/BRIEF.md
# Power-Key Reset and Load-Switch Controller

This block drives the enable of a single battery load switch. Four slow inputs sequence it: an active-low power key, a wake input, a turn-off request and a delay-mode input. A long key press turns the switch on. A longer press while the switch is on forces a reset: the switch opens for a fixed pulse and then closes again by itself. A rising edge on the turn-off request opens the switch, either after a long grace period or almost at once. A discharge enable is driven whenever the switch is open.

A one-cycle tick input, nominally once per millisecond, times every interval, and all interval lengths are parameters counted in ticks. When the delay-mode input is low, the key and turn-off intervals collapse to near-zero values, which suits production test. A 3-bit strap scales the reset hold time. When the same events arrive together, they are resolved by a fixed priority. An event that loses is dropped and is not held for later service.

Top module: `pwrkey_sw_ctrl`

## Requirements
- R1: After reset the switch is on (`sw_en`=1, `dis_en`=0), and all counters and locks are clear.
- R2: `dis_en` is high exactly when `sw_en` is low.
- R3: With the switch on and `full_dly`=1, holding `pwr_key_n` low for the reset hold time opens the switch for T_PULSE ticks, after which it closes again. A release before the hold time ends clears the count and leaves the switch on.
- R4: The reset hold time is T_RST*(k+2)/4 ticks for `rst_scale`=k with k from 0 to 6, giving 0.5 to 2.0 times T_RST in quarter steps. For k=7 it is T_RST.
- R5: If `full_dly` is low before the key falls while the switch is on, the switch opens within a few cycles, and the T_PULSE off time still applies.
- R6: A key that is still held when the switch closes, whether at the end of a reset pulse or at power-on, is locked out. It cannot start a reset until it has returned high.
- R7: With the switch off, holding the key low for T_ON ticks turns the switch on. If `full_dly` was low before the key fell, the switch turns on within a few cycles.
- R8: A rising edge on `wake_in` while the switch is off turns the switch on.
- R9: An `off_in` rising edge that stays high for T_FILT ticks starts turn-off. The switch then opens after T_OFF further ticks if `full_dly` was high at the edge, or after T_OFF_FAST ticks if it was low. A shorter high pulse is ignored.
- R10: The priority order is key first, then wake, then turn-off. A key fall that coincides with an `off_in` rise, or with a `wake_in` rise while the switch is off, is served alone, and the lower-priority event is dropped.
- R11: A key fall or a wake rise during turn-off qualification or the turn-off wait cancels the turn-off. A new turn-off then needs a fresh `off_in` rising edge.
- R12: After a key-initiated power-on, keeping the key held does not trigger a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle timing tick |
| pwr_key_n | input | 1 | Power/reset key, active low, asynchronous |
| wake_in | input | 1 | Wake request, asynchronous |
| off_in | input | 1 | Turn-off request, asynchronous |
| full_dly | input | 1 | 1 selects normal delays, 0 selects near-zero test delays |
| rst_scale | input | 3 | Reset hold time multiplier code |
| sw_en | output | 1 | Load switch enable |
| dis_en | output | 1 | Output discharge enable |

## Verification
The collisions of interest are a key fall arriving in the same cycle as an `off_in` rise while the switch is on, and a key fall arriving together with a `wake_in` rise while the switch is off. The bench changes both inputs on the same clock edge, so they pass through matched synchronizers and reach the controller together. It then judges the result over time. The switch must stay on past the turn-off time, or stay off until the key hold time ends, which shows that only the key was served. A related case, a key or wake event landing inside a pending turn-off, is checked by confirming that the switch stays on while `off_in` is still high.

// File: rtl/pwrkey_pkg.sv
package pwrkey_pkg;
  typedef enum logic [2:0] {
    ST_ON   = 3'd0,
    ST_QUAL = 3'd1,
    ST_WAIT = 3'd2,
    ST_RST  = 3'd3,
    ST_OFF  = 3'd4
  } pk_state_t;
endpackage

// File: rtl/pk_sync.sv
module pk_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= {2{RST_VAL[i]}};
      else        ff_q <= {ff_q[0], d[i]};
    end
    assign q[i] = ff_q[1];
  end
endmodule

// File: rtl/pk_rst_scale.sv
module pk_rst_scale #(
  parameter int T_RST = 7500,
  parameter int CW    = 15
) (
  input  logic [2:0]    code,
  output logic [CW-1:0] limit
);
  localparam int MW = CW + 3;
  logic [3:0]    quarters;
  logic [MW-1:0] prod;

  always_comb begin
    quarters = (code == 3'd7) ? 4'd4 : ({1'b0, code} + 4'd2);
    prod     = MW'(T_RST) * MW'(quarters);
    limit    = prod[CW+1:2];
  end
endmodule

// File: rtl/pk_ctrl_core.sv
module pk_ctrl_core
  import pwrkey_pkg::*;
#(
  parameter int T_ON       = 2300,
  parameter int T_PULSE    = 400,
  parameter int T_OFF      = 7300,
  parameter int T_OFF_FAST = 1,
  parameter int T_FILT     = 1,
  parameter int CW         = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          key_s,
  input  logic          wake_s,
  input  logic          off_s,
  input  logic          dsel_s,
  input  logic [CW-1:0] rst_limit,
  output pk_state_t     st,
  output logic          sw_en,
  output logic          dis_en,
  output logic          key_fall,
  output logic          wake_rise,
  output logic          off_rise,
  output logic          key_lock
);
  localparam logic [CW-1:0] LIM_ON    = CW'(T_ON - 1);
  localparam logic [CW-1:0] LIM_PULSE = CW'(T_PULSE - 1);
  localparam logic [CW-1:0] LIM_OFF   = CW'(T_OFF - 1);
  localparam logic [CW-1:0] LIM_FAST  = CW'(T_OFF_FAST - 1);
  localparam logic [CW-1:0] LIM_FILT  = CW'(T_FILT - 1);

  pk_state_t     st_q, st_n;
  logic [CW-1:0] tmr_q, tmr_n, kcnt_q, kcnt_n, wait_lim;
  logic          lock_q, lock_n, fast_q, fast_n, lock_set;
  logic          key_d, wake_d, off_d;
  logic          key_run, key_zero, hit_rst, hit_on, serve_key, timed;

  always_comb begin
    key_fall  = key_d & ~key_s;
    wake_rise = ~wake_d & wake_s;
    off_rise  = ~off_d & off_s;
    key_zero  = key_fall & ~dsel_s;
    key_run   = ~key_s & ~lock_q & (st_q != ST_RST);
    hit_rst   = key_run & tick & (kcnt_q >= rst_limit - CW'(1));
    hit_on    = key_run & tick & (kcnt_q >= LIM_ON);
    serve_key = key_zero | hit_rst;
    wait_lim  = fast_q ? LIM_FAST : LIM_OFF;
    timed     = (st_q == ST_QUAL) | (st_q == ST_WAIT) | (st_q == ST_RST);
  end

  always_comb begin
    st_n     = st_q;
    fast_n   = fast_q;
    lock_set = 1'b0;
    unique case (st_q)
      ST_ON: begin
        if (serve_key) begin
          st_n = ST_RST; lock_set = 1'b1;
        end else if (!key_fall && !wake_rise && off_rise) begin
          st_n = ST_QUAL; fast_n = ~dsel_s;
        end
      end
      ST_QUAL: begin
        if (serve_key) begin
          st_n = ST_RST; lock_set = 1'b1;
        end else if (key_fall || wake_rise || !off_s) begin
          st_n = ST_ON;
        end else if (tick && (tmr_q >= LIM_FILT)) begin
          st_n = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (serve_key) begin
          st_n = ST_RST; lock_set = 1'b1;
        end else if (key_fall || wake_rise) begin
          st_n = ST_ON;
        end else if (tick && (tmr_q >= wait_lim)) begin
          st_n = ST_OFF;
        end
      end
      ST_RST: begin
        if (tick && (tmr_q >= LIM_PULSE)) st_n = ST_ON;
        lock_set = 1'b1;
      end
      ST_OFF: begin
        if (key_zero || hit_on) begin
          st_n = ST_ON; lock_set = 1'b1;
        end else if (!key_fall && wake_rise) begin
          st_n = ST_ON; lock_set = 1'b1;
        end
      end
      default: st_n = ST_ON;
    endcase
    lock_n = key_s ? 1'b0 : (lock_q | lock_set);
    kcnt_n = key_run ? (kcnt_q + CW'(tick)) : '0;
    tmr_n  = ((st_n != st_q) || !timed) ? '0 : (tmr_q + CW'(tick));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_ON;
      tmr_q  <= '0;
      kcnt_q <= '0;
      lock_q <= 1'b0;
      fast_q <= 1'b0;
      key_d  <= 1'b1;
      wake_d <= 1'b0;
      off_d  <= 1'b0;
    end else begin
      st_q   <= st_n;
      tmr_q  <= tmr_n;
      kcnt_q <= kcnt_n;
      lock_q <= lock_n;
      fast_q <= fast_n;
      key_d  <= key_s;
      wake_d <= wake_s;
      off_d  <= off_s;
    end
  end

  assign st       = st_q;
  assign key_lock = lock_q;
  assign sw_en    = (st_q == ST_ON) | (st_q == ST_QUAL) | (st_q == ST_WAIT);
  assign dis_en   = (st_q == ST_RST) | (st_q == ST_OFF);
endmodule

// File: rtl/pwrkey_sw_ctrl.sv
module pwrkey_sw_ctrl
  import pwrkey_pkg::*;
#(
  parameter int T_ON       = 2300,
  parameter int T_RST      = 7500,
  parameter int T_PULSE    = 400,
  parameter int T_OFF      = 7300,
  parameter int T_OFF_FAST = 1,
  parameter int T_FILT     = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       pwr_key_n,
  input  logic       wake_in,
  input  logic       off_in,
  input  logic       full_dly,
  input  logic [2:0] rst_scale,
  output logic       sw_en,
  output logic       dis_en
);
  localparam int MAX_A = (2 * T_RST > T_ON) ? 2 * T_RST : T_ON;
  localparam int MAX_B = (T_OFF > T_PULSE) ? T_OFF : T_PULSE;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAX_T + 1) + 1;

  logic [3:0]    sync_q;
  logic [CW-1:0] rst_limit;
  pk_state_t     st;
  logic          key_fall, wake_rise, off_rise, key_lock;

  pk_sync #(.W(4), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({full_dly, off_in, wake_in, pwr_key_n}),
    .q(sync_q)
  );

  pk_rst_scale #(.T_RST(T_RST), .CW(CW)) u_scale (
    .code(rst_scale), .limit(rst_limit)
  );

  pk_ctrl_core #(
    .T_ON(T_ON), .T_PULSE(T_PULSE), .T_OFF(T_OFF),
    .T_OFF_FAST(T_OFF_FAST), .T_FILT(T_FILT), .CW(CW)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick_ms),
    .key_s(sync_q[0]), .wake_s(sync_q[1]), .off_s(sync_q[2]), .dsel_s(sync_q[3]),
    .rst_limit(rst_limit),
    .st(st), .sw_en(sw_en), .dis_en(dis_en),
    .key_fall(key_fall), .wake_rise(wake_rise), .off_rise(off_rise),
    .key_lock(key_lock)
  );
endmodule

// File: rtl/pk_sva.sv
module pk_sva
  import pwrkey_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input pk_state_t st,
  input logic      sw_en,
  input logic      dis_en,
  input logic      key_fall,
  input logic      wake_rise,
  input logic      off_rise,
  input logic      key_lock
);
  a_r2_discharge_opposite: assert property (@(posedge clk) disable iff (!rst_n)
    dis_en != sw_en);

  a_r8_wake_serves_off: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF && wake_rise && !key_fall) |=> sw_en);

  a_r10_key_beats_off: assert property (@(posedge clk) disable iff (!rst_n)
    (key_fall && off_rise) |=> (st != ST_QUAL));

  a_r11_turnoff_aborted: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_WAIT || st == ST_QUAL) && (key_fall || wake_rise))
      |=> !(st == ST_WAIT || st == ST_QUAL));

  a_r6_locked_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ON && key_lock) |=> (st != ST_RST));

  a_r9_off_only_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ON || st == ST_QUAL || st == ST_RST) |=> (st != ST_OFF));
endmodule

bind pwrkey_sw_ctrl pk_sva u_sva (
  .clk(clk), .rst_n(rst_n), .st(st), .sw_en(sw_en), .dis_en(dis_en),
  .key_fall(key_fall), .wake_rise(wake_rise), .off_rise(off_rise),
  .key_lock(key_lock)
);

// File: tb/pwrkey_sw_ctrl_tb.sv
`timescale 1ns/1ps
module pwrkey_sw_ctrl_tb;
  localparam int T_ON = 23, T_RST = 40, T_PULSE = 10, T_OFF = 30, T_FAST = 1, T_FILT = 2;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic key_n = 1'b1, wake = 1'b0, offr = 1'b0, fdly = 1'b1;
  logic [2:0] scale = 3'd2;
  logic sw_en, dis_en;
  int checks = 0, errors = 0, div = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    div  <= (div == 3) ? 0 : div + 1;
    tick <= (div == 3);
  end

  pwrkey_sw_ctrl #(.T_ON(T_ON), .T_RST(T_RST), .T_PULSE(T_PULSE), .T_OFF(T_OFF),
                   .T_OFF_FAST(T_FAST), .T_FILT(T_FILT)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick), .pwr_key_n(key_n), .wake_in(wake),
    .off_in(offr), .full_dly(fdly), .rst_scale(scale), .sw_en(sw_en), .dis_en(dis_en));

  function automatic int hold_lim(input int code);
    return (code == 7) ? T_RST : (T_RST * (code + 2)) / 4;
  endfunction

  task automatic tk(input int n);
    repeat (n) begin
      do @(posedge clk); while (tick !== 1'b1);
    end
    @(negedge clk);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic exp_sw);
    checks++;
    if (sw_en !== exp_sw || dis_en !== ~exp_sw) begin
      errors++;
      $display("FAIL %s: sw_en=%0b dis_en=%0b expected sw_en=%0b dis_en=%0b",
               tag, sw_en, dis_en, exp_sw, ~exp_sw);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run not finished actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    cyc(4); rst_n = 1'b1; cyc(3);
    chk("R1 reset state on", 1'b1);

    // R3: short press, no reset
    key_n = 1'b0; tk(hold_lim(2) - 3);
    chk("R3 short hold keeps on", 1'b1);
    key_n = 1'b1; tk(2);
    chk("R3 release clears count", 1'b1);

    // R3/R4 long press with default multiplier, then R6 lockout
    key_n = 1'b0; tk(hold_lim(2) + 2);
    chk("R3 long hold opens switch", 1'b0);
    tk(T_PULSE - 5);
    chk("R3 pulse still off", 1'b0);
    tk(6);
    chk("R3 switch recloses", 1'b1);
    tk(hold_lim(2) + 5);
    chk("R6 held key locked out", 1'b1);
    key_n = 1'b1; tk(2);

    // R4: random multiplier codes and hold lengths
    for (int i = 0; i < 8; i++) begin
      int code, lim;
      bit longp;
      code  = (i == 0) ? 7 : int'($urandom % 8);
      lim   = hold_lim(code);
      longp = $urandom % 2;
      scale = code[2:0];
      cyc(2);
      key_n = 1'b0;
      tk(longp ? lim + 2 : lim - 3);
      chk($sformatf("R4 code %0d hold %s", code, longp ? "long" : "short"), longp ? 1'b0 : 1'b1);
      key_n = 1'b1;
      tk(T_PULSE + 3);
      chk($sformatf("R4 code %0d settles on", code), 1'b1);
    end
    scale = 3'd2; cyc(2);

    // R5: zero-delay reset
    fdly = 1'b0; tk(1);
    key_n = 1'b0; cyc(10);
    chk("R5 immediate reset", 1'b0);
    tk(T_PULSE - 3);
    chk("R5 pulse kept", 1'b0);
    tk(5);
    chk("R5 recloses after pulse", 1'b1);
    key_n = 1'b1; fdly = 1'b1; tk(2);

    // R9: delayed turn-off
    offr = 1'b1; tk(T_OFF - 4);
    chk("R9 delayed off still on", 1'b1);
    tk(8);
    chk("R9 delayed off opens", 1'b0);
    offr = 1'b0; tk(2);

    // R8: wake from off
    wake = 1'b1; cyc(10);
    chk("R8 wake turns on", 1'b1);
    wake = 1'b0; tk(2);

    // R9: fast turn-off
    fdly = 1'b0; tk(1);
    offr = 1'b1; tk(5);
    chk("R9 fast off opens", 1'b0);
    offr = 1'b0; fdly = 1'b1; tk(2);

    // R7 and R12: key power-on then held
    key_n = 1'b0; tk(T_ON - 4);
    chk("R7 key power-on pending", 1'b0);
    tk(6);
    chk("R7 key power-on", 1'b1);
    tk(hold_lim(2) + 5);
    chk("R12 held key no reset", 1'b1);
    key_n = 1'b1; tk(2);

    // R9: pulse shorter than filter ignored
    offr = 1'b1; cyc(2); offr = 1'b0;
    tk(T_OFF + 5);
    chk("R9 short off pulse ignored", 1'b1);

    // R11: wake aborts wait, re-arm needs new edge
    offr = 1'b1; tk(10);
    wake = 1'b1; tk(1); wake = 1'b0;
    tk(T_OFF + 5);
    chk("R11 wake cancels turn-off", 1'b1);
    offr = 1'b0; tk(1); offr = 1'b1;
    tk(T_OFF + 5);
    chk("R11 new edge turns off", 1'b0);
    offr = 1'b0; tk(2);

    // R10: key and wake together while off
    key_n = 1'b0; wake = 1'b1;
    tk(T_ON - 4);
    chk("R10 wake dropped under key", 1'b0);
    tk(6);
    chk("R10 key served", 1'b1);
    key_n = 1'b1; wake = 1'b0; tk(2);

    // R7: zero-delay power-on, then R12
    fdly = 1'b0; tk(1);
    offr = 1'b1; tk(5); offr = 1'b0; tk(2);
    chk("R9 fast off before zero power-on", 1'b0);
    key_n = 1'b0; cyc(10);
    chk("R7 immediate power-on", 1'b1);
    tk(10);
    chk("R12 held key after zero power-on", 1'b1);
    key_n = 1'b1; fdly = 1'b1; tk(2);

    // R10: key and off edge together while on
    key_n = 1'b0; offr = 1'b1;
    tk(T_OFF + 5);
    chk("R10 off dropped under key", 1'b1);
    key_n = 1'b1; tk(2); offr = 1'b0; tk(2);
    chk("R10 still on after release", 1'b1);

    // R11: key aborts wait
    offr = 1'b1; tk(10);
    key_n = 1'b0; tk(2); key_n = 1'b1;
    tk(T_OFF + 5);
    chk("R11 key cancels turn-off", 1'b1);
    offr = 1'b0; tk(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule